// File: doc/BRIEF.md
# Non-Stoppable Watchdog Timer

This block is a supervision counter that forces an internal reset if software stops looking after it. It advances once per machine cycle, on a one-cycle enable pulse from the clock divider. Software starts it with a single write. After that no write can stop it. Only an external hardware reset returns it to idle. While it runs, software must refresh it with a two-write sequence. If the count reaches the trip value first, the block drives its internal reset output for a fixed number of machine cycles.

The default width is 16 bits and the trip value is `2**CNT_W - TRIP_GAP`, which gives FFFCh by default. That is 65532 machine cycles after a start or a refresh. A watchdog reset leaves the watchdog running and leaves its status bit set, so software can tell a watchdog reset from an external reset. An external reset stops the watchdog, clears the count and clears the status bit. When the watchdog fires, the counter restarts from zero. It keeps counting through the reset pulse, so the pulse cannot retrigger itself.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first start write, `wdt_rst_o` is 0 and `wdt_stat_o` is 0. Any number of `tick_en` pulses in this state produces no internal reset.
- R2: The counter advances only in cycles with `tick_en` = 1. `wdt_rst_o` rises right after the clock edge of the TRIP-th tick following a start or refresh, where TRIP = 2**CNT_W - TRIP_GAP (FFFCh by default). Cycles without a tick do not count.
- R3: A write (`wr_strobe` = 1) with `wr_start` = 1 and `wr_arm` = 0 to an idle watchdog starts it from count zero and sets `wdt_stat_o` after that clock edge.
- R4: A refresh is a write with `wr_arm` = 1, followed by the next write having `wr_arm` = 0 and `wr_start` = 1. This clears the counter, and the next trip comes TRIP ticks later. A write with both bits set counts only as the arm write.
- R5: Two cases do not clear the counter: a start write with no arm write before it, and an arm write followed by any write other than a start write.
- R6: Once running, the watchdog keeps running whatever is written, including writes with both bits 0.
- R7: The internal reset lasts exactly RST_CYCLES ticks (4 by default). Cycles without a tick lengthen the pulse.
- R8: When the watchdog fires, the counter restarts from zero and keeps counting through the pulse. The next trip is therefore TRIP ticks after the previous one, and the pulse never retriggers itself.
- R9: `wdt_stat_o` and the running state both stay set through and after a watchdog reset.
- R10: Writes made while `wdt_rst_o` is high are ignored, including a complete refresh sequence.
- R11: Driving `rst_n` low clears `wdt_rst_o`, `wdt_stat_o` and the count at once, even in the middle of a pulse. Afterwards the watchdog stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External hardware reset, active low, asynchronous assert |
| tick_en | input | 1 | Machine-cycle enable, one pulse per machine cycle |
| wr_strobe | input | 1 | Control write strobe |
| wr_arm | input | 1 | Refresh-arm bit of the control write |
| wr_start | input | 1 | Start bit of the control write |
| wdt_rst_o | output | 1 | Internal reset request |
| wdt_stat_o | output | 1 | Set once started; survives watchdog reset |

## Verification
The assertions take three things for granted about the inputs:
- RST_CYCLES is smaller than TRIP, so a new trip cannot fall inside a running pulse.
- A write and a tick never share a cycle. A clear therefore never races with a trip.
- `rst_n` changes only between clock edges.

The stimulus keeps within these assumptions. It drives every write in a cycle with no tick, and changes `rst_n` on the falling clock edge. A reduced 6-bit configuration (TRIP = 60) is used, so that every refresh point can be swept. Idle cycles are inserted between ticks in a pattern that changes from one sweep point to the next.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_ARM   = 2'd1,
    WR_TRIG  = 2'd2,
    WR_OTHER = 2'd3
  } wr_kind_e;

  // Classify one control write; arm dominates when both bits are set.
  function automatic wr_kind_e classify_wr(input logic strobe,
                                           input logic arm,
                                           input logic start);
    wr_kind_e k;
    if (!strobe)     k = WR_IDLE;
    else if (arm)    k = WR_ARM;
    else if (start)  k = WR_TRIG;
    else             k = WR_OTHER;
    return k;
  endfunction

endpackage

// File: rtl/wdt_refresh_seq.sv
module wdt_refresh_seq
  import wdt_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic arm_bit,
  input  logic start_bit,
  input  logic running,
  output logic start_pulse,
  output logic refresh_pulse
);

  wr_kind_e kind;
  logic     armed_q;
  logic     armed_d;

  always_comb begin
    kind          = classify_wr(wr_en, arm_bit, start_bit);
    armed_d       = armed_q;
    if (kind != WR_IDLE) begin
      armed_d = (kind == WR_ARM);
    end
    start_pulse   = (kind == WR_TRIG) && !running;
    refresh_pulse = (kind == WR_TRIG) && running && armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R4: an arm is consumed by the refresh that uses it
  a_r4_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |=> !armed_q);

  // R5: a start write without a pending arm never refreshes
  a_r5_no_refresh_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !arm_bit && start_bit && !armed_q) |-> !refresh_pulse);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TRIP_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic clr,
  output logic trip
);

  localparam int unsigned TRIP_INT = (1 << CNT_W) - TRIP_GAP;
  localparam logic [CNT_W-1:0] PRE_TRIP = CNT_W'(TRIP_INT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  always_comb begin
    adv   = run && tick;
    trip  = adv && !clr && (cnt_q == PRE_TRIP);
    cnt_d = cnt_q;
    if (clr || trip) cnt_d = '0;
    else if (adv)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: without a tick or a clear the count holds
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

  // R8: a trip restarts the count from zero
  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (cnt_q == '0));

  // R1: an idle watchdog holds zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic tick,
  output logic busy
);

  localparam int unsigned RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [RC_W-1:0] LOAD = RC_W'(RST_CYCLES);

  logic [RC_W-1:0] left_q;
  logic [RC_W-1:0] left_d;

  always_comb begin
    left_d = left_q;
    if (trip)                      left_d = LOAD;
    else if (tick && left_q != '0) left_d = left_q - 1'b1;
    busy = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  // R8: no trip while a pulse is still running
  a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> !busy);

  // R7: the pulse only ends on a machine-cycle tick
  a_r7_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TRIP_GAP   = 4,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic wr_strobe,
  input  logic wr_arm,
  input  logic wr_start,
  output logic wdt_rst_o,
  output logic wdt_stat_o
);

  logic run_q;
  logic run_d;
  logic busy;
  logic wr_en;
  logic start_pulse;
  logic refresh_pulse;
  logic clr;
  logic trip;

  always_comb begin
    wr_en = wr_strobe && !busy;
    clr   = start_pulse || refresh_pulse;
    run_d = run_q || start_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  wdt_refresh_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .arm_bit       (wr_arm),
    .start_bit     (wr_start),
    .running       (run_q),
    .start_pulse   (start_pulse),
    .refresh_pulse (refresh_pulse)
  );

  wdt_counter #(
    .CNT_W    (CNT_W),
    .TRIP_GAP (TRIP_GAP)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .tick  (tick_en),
    .clr   (clr),
    .trip  (trip)
  );

  wdt_rst_stretch #(
    .RST_CYCLES (RST_CYCLES)
  ) u_str (
    .clk   (clk),
    .rst_n (rst_n),
    .trip  (trip),
    .tick  (tick_en),
    .busy  (busy)
  );

  assign wdt_rst_o  = busy;
  assign wdt_stat_o = run_q;

  // R6: once running, only the external reset stops the watchdog
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  // R9: the status bit is set during every watchdog reset
  a_r9_stat_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> wdt_stat_o);

  // R10: no start or refresh takes effect during the pulse
  a_r10_writes_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> !(start_pulse || refresh_pulse));

  // R3: a start write leaves the status bit set
  a_r3_start_sets_stat: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> wdt_stat_o);

endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;

  localparam int unsigned W    = 6;
  localparam int unsigned GAP  = 4;
  localparam int unsigned RSTC = 4;
  localparam int TRIP = (1 << W) - GAP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic wr_strobe = 1'b0;
  logic wr_arm = 1'b0;
  logic wr_start = 1'b0;
  logic wdt_rst_o;
  logic wdt_stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_guard #(.CNT_W(W), .TRIP_GAP(GAP), .RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_strobe(wr_strobe),
    .wr_arm(wr_arm), .wr_start(wr_start), .wdt_rst_o(wdt_rst_o),
    .wdt_stat_o(wdt_stat_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic ws, input logic a, input logic s);
    @(negedge clk);
    tick_en = t; wr_strobe = ws; wr_arm = a; wr_start = s;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic s);
    cyc(1'b0, 1'b1, a, s);
  endtask

  // n ticks, each followed by gap idle cycles; returns whether reset was seen
  task automatic ticks(input int n, input int gap, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      if (wdt_rst_o) seen = 1'b1;
      for (int g = 0; g < gap; g++) begin
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        if (wdt_rst_o) seen = 1'b1;
      end
    end
  endtask

  task automatic expect_fire(input int n, input int gap, input string req);
    bit seen;
    ticks(n - 1, gap, seen);
    chk(!seen, req, int'(seen), 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk(wdt_rst_o == 1'b1, req, int'(wdt_rst_o), 1);
  endtask

  task automatic pulse_len(input int gap, output int len);
    len = 0;
    while (wdt_rst_o && len < 20) begin
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
      if (wdt_rst_o) begin
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        len++;
      end
    end
  endtask

  task automatic ext_reset();
    @(negedge clk);
    tick_en = 1'b0; wr_strobe = 1'b0; wr_arm = 1'b0; wr_start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    bit seen;
    int len;

    repeat (3) @(negedge clk);
    #1;
    chk(wdt_rst_o == 1'b0 && wdt_stat_o == 1'b0, "R1 in reset",
        int'({wdt_rst_o, wdt_stat_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: idle watchdog never fires
    ticks(TRIP + 10, 0, seen);
    chk(!seen && wdt_stat_o == 1'b0, "R1 idle", int'({seen, wdt_stat_o}), 0);

    // R3: start sets status; R2: fire at the TRIP-th tick
    wr(1'b0, 1'b1);
    chk(wdt_stat_o == 1'b1, "R3 status", int'(wdt_stat_o), 1);
    expect_fire(TRIP, 0, "R2 first trip");

    // R10: a full refresh during the pulse is ignored
    wr(1'b1, 1'b0);
    wr(1'b0, 1'b1);
    chk(wdt_rst_o == 1'b1, "R10 pulse held", int'(wdt_rst_o), 1);
    // R7: pulse length counted in ticks, idle cycles in between
    pulse_len(1, len);
    chk(len == RSTC, "R7 pulse length gapped", len, RSTC);
    chk(wdt_stat_o == 1'b1, "R9 status survives", int'(wdt_stat_o), 1);

    // R8 and R10: next trip TRIP ticks after the previous one
    expect_fire(TRIP - RSTC, 0, "R8 R10 next trip");
    pulse_len(0, len);
    chk(len == RSTC, "R7 pulse length", len, RSTC);
    chk(wdt_stat_o == 1'b1, "R9 status after second", int'(wdt_stat_o), 1);

    // R5 and R6: lone start, zero write, arm broken by another write
    ext_reset();
    wr(1'b0, 1'b1);
    ticks(20, 0, seen);
    wr(1'b0, 1'b1);
    wr(1'b0, 1'b0);
    wr(1'b1, 1'b0);
    wr(1'b0, 1'b0);
    wr(1'b0, 1'b1);
    chk(wdt_stat_o == 1'b1, "R6 still running", int'(wdt_stat_o), 1);
    expect_fire(TRIP - 20, 0, "R5 no clear");

    // R11: external reset in mid-pulse
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(wdt_rst_o == 1'b0 && wdt_stat_o == 1'b0, "R11 async clear",
        int'({wdt_rst_o, wdt_stat_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    ticks(TRIP + 5, 0, seen);
    chk(!seen, "R11 stays idle", int'(seen), 0);

    // R4: a write with both bits set acts as the arm write
    wr(1'b0, 1'b1);
    ticks(10, 0, seen);
    wr(1'b1, 1'b1);
    wr(1'b0, 1'b1);
    expect_fire(TRIP, 0, "R4 combined arm");

    // R4: refresh sweep over every point, varying idle gaps
    for (int k = 1; k < TRIP; k++) begin
      ext_reset();
      wr(1'b0, 1'b1);
      ticks(k, k % 3, seen);
      wr(1'b1, 1'b0);
      wr(1'b0, 1'b1);
      expect_fire(TRIP, k % 3, "R4 refresh sweep");
    end

    finish_run();
  end

endmodule